// File: doc/BRIEF.md
# Recoverable NMI and Double-Fault Tracker

This block sits beside the machine-mode trap logic of a small RISC-V core. It decides when a non-maskable interrupt request is taken. When one is taken, it keeps a private copy of the previous-privilege field, the previous-interrupt-enable bit, the exception PC and the cause register, because the trap that follows overwrites them. When the handler returns with MRET, the block hands those four values back in a single one-cycle restore strobe, so that the code the NMI interrupted can carry on.

The same block keeps a two-bit status word. One bit is set whenever a synchronous exception is entered outside debug mode, and an MRET clears it. The other bit marks a second synchronous exception taken while the first bit was still set, which is a double fault. The CSR file reads the status word and can write it back through a simple write strobe.

Top module: `nmi_recovery_tracker`

## Requirements
- R1: After reset, `nmi_mode_o`, `restore_o`, all four restore value outputs and `status_o` are zero.
- R2: An NMI request is taken only when the block is not in NMI mode, `dbg_mode_i` is low and `dbg_halt_req_i` is low. `nmi_take_o` is high in the same cycle as the request, and `nmi_mode_o` is high from the next cycle on.
- R3: The external and internal request lines both lead into the same NMI mode. If both are raised in the same cycle, the external one is taken. While NMI mode is active, every further request is ignored: there is no take strobe and the saved values do not change.
- R4: `nmi_cause_o` is 0xFFFFFFE0 when the internal source is taken and `EXT_NMI_CAUSE` (default 0x8000001F) when the external source is taken.
- R5: When an NMI is taken, the values on `mpp_i`, `mpie_i`, `mepc_i` and `mcause_i` in that cycle are saved.
- R6: An MRET is a cycle with `retire_i` high, `retire_insn_i` equal to 0x30200073 and `retire_trap_i` low. Any other word, or a set trap flag, does not count as an MRET.
- R7: An MRET in NMI mode makes `restore_o` high for exactly one cycle, the cycle after the MRET. In that cycle the four saved values are on the restore outputs and `nmi_mode_o` is low.
- R8: An MRET clears status bit 6 from the next cycle on. Status bit 7 is left unchanged.
- R9: A synchronous exception entry (`sync_exc_i`) outside debug mode sets status bit 6. If bit 6 was already set, it also sets bit 7. In debug mode the entry has no effect on the status word.
- R10: A CSR write (`csr_wr_i`) loads status bits 6 and 7 from `csr_wdata_i[6]` and `csr_wdata_i[7]` and takes priority over any other status event in the same cycle. Bit 7 changes only through a CSR write or an exception entry, and every other bit of `status_o` reads zero.
- R11: If a synchronous exception entry and an MRET fall in the same cycle, the exception wins and bit 6 ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_ext_i | input | 1 | External NMI request |
| nmi_int_i | input | 1 | Internal NMI request |
| dbg_mode_i | input | 1 | Core is in debug mode |
| dbg_halt_req_i | input | 1 | Debug halt request pending |
| sync_exc_i | input | 1 | Strobe: synchronous exception entry |
| retire_i | input | 1 | Strobe: an instruction retires |
| retire_insn_i | input | 32 | Retired instruction word |
| retire_trap_i | input | 1 | Retiring instruction trapped |
| mpp_i | input | 2 | Current previous-privilege field |
| mpie_i | input | 1 | Current previous-interrupt-enable bit |
| mepc_i | input | 32 | Current exception PC |
| mcause_i | input | 32 | Current cause register |
| csr_wr_i | input | 1 | Strobe: write to the status word |
| csr_wdata_i | input | 32 | Data for the status word write |
| nmi_take_o | output | 1 | An NMI is taken this cycle |
| nmi_cause_o | output | 32 | Cause value of the NMI being taken |
| nmi_mode_o | output | 1 | NMI mode active |
| restore_o | output | 1 | One-cycle strobe: write the restore values back |
| restore_mpp_o | output | 2 | Saved previous-privilege field |
| restore_mpie_o | output | 1 | Saved previous-interrupt-enable bit |
| restore_mepc_o | output | 32 | Saved exception PC |
| restore_mcause_o | output | 32 | Saved cause register |
| status_o | output | 32 | Status word: bit 6 sync-exception-seen, bit 7 double-fault-seen |

## Verification
The assertions assume that every strobe input lasts a single cycle for each event. They also assume that the core never retires an MRET while it is taking an NMI trap in the same cycle, which is guaranteed because a take is only possible outside NMI mode. The stimulus drives each event for one cycle and then returns all strobes to zero. It raises NMI requests only between handler returns, or deliberately inside NMI mode to show that they are ignored. Events that may legally coincide, such as both NMI lines together, an exception entry together with an MRET, or a CSR write together with an exception entry, are driven in the same cycle on purpose.

// File: rtl/nt_pkg.sv
package nt_pkg;
  parameter int unsigned NT_XLEN = 32;
  localparam logic [NT_XLEN-1:0] MRET_WORD     = 32'h3020_0073;
  localparam logic [NT_XLEN-1:0] INT_NMI_CAUSE = 32'hFFFF_FFE0;
  localparam int unsigned SEEN_BIT = 6;
  localparam int unsigned DF_BIT   = 7;

  typedef struct packed {
    logic [1:0]         mpp;
    logic               mpie;
    logic [NT_XLEN-1:0] epc;
    logic [NT_XLEN-1:0] cause;
  } nt_shadow_t;

  typedef struct packed {
    logic df;
    logic seen;
  } nt_stat_t;

  function automatic logic nt_is_mret(input logic vld, input logic [NT_XLEN-1:0] insn,
                                      input logic trap);
    return vld && !trap && (insn == MRET_WORD);
  endfunction

  function automatic nt_stat_t nt_stat_next(input nt_stat_t cur, input logic exc,
                                            input logic mret, input logic wr,
                                            input logic w_seen, input logic w_df);
    nt_stat_t nx;
    nx = cur;
    if (wr) begin
      nx.seen = w_seen;
      nx.df   = w_df;
    end else if (exc) begin
      nx.seen = 1'b1;
      nx.df   = cur.df | cur.seen;
    end else if (mret) begin
      nx.seen = 1'b0;
    end
    return nx;
  endfunction
endpackage

// File: rtl/nt_nmi_gate.sv
module nt_nmi_gate
  import nt_pkg::*;
#(
  parameter logic [NT_XLEN-1:0] EXT_CAUSE = 32'h8000_001F
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_req_i,
  input  logic               int_req_i,
  input  logic               dbg_mode_i,
  input  logic               halt_req_i,
  input  logic               leave_i,
  output logic               accept_o,
  output logic [NT_XLEN-1:0] cause_o,
  output logic               mode_o
);
  logic mode_q;
  logic allowed;

  assign allowed  = !mode_q && !dbg_mode_i && !halt_req_i;
  assign accept_o = allowed && (ext_req_i || int_req_i);
  assign cause_o  = ext_req_i ? EXT_CAUSE : INT_NMI_CAUSE;
  assign mode_o   = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= 1'b0;
    else if (accept_o) mode_q <= 1'b1;
    else if (leave_i)  mode_q <= 1'b0;
  end
endmodule

// File: rtl/nt_shadow.sv
module nt_shadow
  import nt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       capture_i,
  input  nt_shadow_t live_i,
  input  logic       restore_req_i,
  output logic       restore_o,
  output nt_shadow_t saved_o
);
  nt_shadow_t saved_q;
  logic       restore_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      saved_q   <= '0;
      restore_q <= 1'b0;
    end else begin
      restore_q <= restore_req_i;
      if (capture_i) saved_q <= live_i;
    end
  end

  assign restore_o = restore_q;
  assign saved_o   = saved_q;
endmodule

// File: rtl/nt_status.sv
module nt_status
  import nt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exc_i,
  input  logic               dbg_mode_i,
  input  logic               mret_i,
  input  logic               wr_i,
  input  logic [NT_XLEN-1:0] wdata_i,
  output logic [NT_XLEN-1:0] status_o
);
  nt_stat_t stat_q;
  nt_stat_t stat_d;

  always_comb begin
    stat_d = nt_stat_next(stat_q, exc_i && !dbg_mode_i, mret_i, wr_i,
                          wdata_i[SEEN_BIT], wdata_i[DF_BIT]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  always_comb begin
    status_o           = '0;
    status_o[SEEN_BIT] = stat_q.seen;
    status_o[DF_BIT]   = stat_q.df;
  end
endmodule

// File: rtl/nmi_recovery_tracker.sv
module nmi_recovery_tracker
  import nt_pkg::*;
#(
  parameter logic [31:0] EXT_NMI_CAUSE = 32'h8000_001F
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        nmi_ext_i,
  input  logic        nmi_int_i,
  input  logic        dbg_mode_i,
  input  logic        dbg_halt_req_i,
  input  logic        sync_exc_i,
  input  logic        retire_i,
  input  logic [31:0] retire_insn_i,
  input  logic        retire_trap_i,
  input  logic [1:0]  mpp_i,
  input  logic        mpie_i,
  input  logic [31:0] mepc_i,
  input  logic [31:0] mcause_i,
  input  logic        csr_wr_i,
  input  logic [31:0] csr_wdata_i,
  output logic        nmi_take_o,
  output logic [31:0] nmi_cause_o,
  output logic        nmi_mode_o,
  output logic        restore_o,
  output logic [1:0]  restore_mpp_o,
  output logic        restore_mpie_o,
  output logic [31:0] restore_mepc_o,
  output logic [31:0] restore_mcause_o,
  output logic [31:0] status_o
);
  logic       mret_w;
  logic       accept_w;
  logic       leave_w;
  nt_shadow_t live_w;
  nt_shadow_t saved_w;

  assign mret_w  = nt_is_mret(retire_i, retire_insn_i, retire_trap_i);
  assign leave_w = mret_w && nmi_mode_o;
  assign live_w  = '{mpp: mpp_i, mpie: mpie_i, epc: mepc_i, cause: mcause_i};

  nt_nmi_gate #(.EXT_CAUSE(EXT_NMI_CAUSE)) i_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_req_i  (nmi_ext_i),
    .int_req_i  (nmi_int_i),
    .dbg_mode_i (dbg_mode_i),
    .halt_req_i (dbg_halt_req_i),
    .leave_i    (leave_w),
    .accept_o   (accept_w),
    .cause_o    (nmi_cause_o),
    .mode_o     (nmi_mode_o)
  );

  nt_shadow i_shadow (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .capture_i     (accept_w),
    .live_i        (live_w),
    .restore_req_i (leave_w),
    .restore_o     (restore_o),
    .saved_o       (saved_w)
  );

  nt_status i_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .exc_i      (sync_exc_i),
    .dbg_mode_i (dbg_mode_i),
    .mret_i     (mret_w),
    .wr_i       (csr_wr_i),
    .wdata_i    (csr_wdata_i),
    .status_o   (status_o)
  );

  assign nmi_take_o       = accept_w;
  assign restore_mpp_o    = saved_w.mpp;
  assign restore_mpie_o   = saved_w.mpie;
  assign restore_mepc_o   = saved_w.epc;
  assign restore_mcause_o = saved_w.cause;
endmodule

// File: rtl/nt_checker.sv
module nt_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        dbg_mode_i,
  input logic        dbg_halt_req_i,
  input logic        nmi_ext_i,
  input logic        csr_wr_i,
  input logic        accept_w,
  input logic        mret_w,
  input logic        nmi_take_o,
  input logic [31:0] nmi_cause_o,
  input logic        nmi_mode_o,
  input logic        restore_o,
  input logic [31:0] status_o
);
  AST_NO_TAKE_IN_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_mode_o |-> !nmi_take_o); // R2
  AST_NO_TAKE_IN_DEBUG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_mode_i || dbg_halt_req_i) |-> !nmi_take_o); // R2
  AST_TAKE_ENTERS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_w |=> nmi_mode_o); // R3
  AST_EXT_CAUSE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_take_o && !nmi_ext_i) |-> (nmi_cause_o == 32'hFFFF_FFE0)); // R4
  AST_RESTORE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |=> !restore_o); // R7
  AST_RESTORE_AFTER_MRET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_w && nmi_mode_o) |=> (restore_o && !nmi_mode_o)); // R7
  AST_DF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[7] && !csr_wr_i) |=> status_o[7]); // R10
  AST_DF_NEEDS_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(status_o[7]) && !$past(csr_wr_i)) |-> $past(status_o[6])); // R9
  AST_OTHER_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & ~32'h0000_00C0) == 32'h0); // R10
endmodule

bind nmi_recovery_tracker nt_checker i_nt_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .dbg_mode_i     (dbg_mode_i),
  .dbg_halt_req_i (dbg_halt_req_i),
  .nmi_ext_i      (nmi_ext_i),
  .csr_wr_i       (csr_wr_i),
  .accept_w       (accept_w),
  .mret_w         (mret_w),
  .nmi_take_o     (nmi_take_o),
  .nmi_cause_o    (nmi_cause_o),
  .nmi_mode_o     (nmi_mode_o),
  .restore_o      (restore_o),
  .status_o       (status_o)
);

// File: tb/test_nmi_recovery_tracker.sv
`timescale 1ns/1ps
module test_nmi_recovery_tracker;
  localparam logic [31:0] MRET   = 32'h3020_0073;
  localparam logic [31:0] EXT_C  = 32'h8000_001F;
  localparam logic [31:0] INT_C  = 32'hFFFF_FFE0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_ext, nmi_int, dbg_mode, halt_req, sync_exc, retire, trap, mpie, csr_wr;
  logic [31:0] insn, mepc, mcause, wdata;
  logic [1:0] mpp;
  logic        take, mode, restore, r_mpie;
  logic [1:0]  r_mpp;
  logic [31:0] cause, r_mepc, r_mcause, status;

  typedef struct packed {
    logic [1:0]  mpp;
    logic        mpie;
    logic [31:0] epc;
    logic [31:0] cause;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  nmi_recovery_tracker i_nmi_recovery_tracker (
    .clk_i(clk), .rst_ni(rst_n), .nmi_ext_i(nmi_ext), .nmi_int_i(nmi_int),
    .dbg_mode_i(dbg_mode), .dbg_halt_req_i(halt_req), .sync_exc_i(sync_exc),
    .retire_i(retire), .retire_insn_i(insn), .retire_trap_i(trap),
    .mpp_i(mpp), .mpie_i(mpie), .mepc_i(mepc), .mcause_i(mcause),
    .csr_wr_i(csr_wr), .csr_wdata_i(wdata), .nmi_take_o(take), .nmi_cause_o(cause),
    .nmi_mode_o(mode), .restore_o(restore), .restore_mpp_o(r_mpp),
    .restore_mpie_o(r_mpie), .restore_mepc_o(r_mepc), .restore_mcause_o(r_mcause),
    .status_o(status)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic idle();
    nmi_ext = 0; nmi_int = 0; dbg_mode = 0; halt_req = 0; sync_exc = 0;
    retire = 0; trap = 0; insn = 32'h0; csr_wr = 0; wdata = 32'h0;
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic set_live(input logic [1:0] p, input logic e, input logic [31:0] pc,
                          input logic [31:0] c);
    mpp = p; mpie = e; mepc = pc; mcause = c;
  endtask

  // driver side of the scoreboard: an accepted NMI pushes the values to restore later
  task automatic push_live();
    exp_t it;
    it.mpp = mpp; it.mpie = mpie; it.epc = mepc; it.cause = mcause;
    exp_q.push_back(it);
  endtask

  task automatic do_mret();
    retire = 1; insn = MRET; trap = 0;
    cyc(); idle();
  endtask

  // monitor: every restore strobe is compared against the oldest expected item (R5, R7)
  always @(negedge clk) begin
    if (rst_n && restore) begin
      exp_t got;
      got.mpp = r_mpp; got.mpie = r_mpie; got.epc = r_mepc; got.cause = r_mcause;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected restore", {31'h0, got[66:34]}, 64'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(got == e, "R5 restored values", got[63:0], e[63:0]);
        chk(got.mpp == e.mpp && got.mpie == e.mpie, "R5 mpp/mpie",
            {61'h0, got.mpp, got.mpie}, {61'h0, e.mpp, e.mpie});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 64'h0, 64'h1);
    report();
  end

  initial begin
    idle();
    set_live(2'd0, 1'b0, 32'h0, 32'h0);
    cyc(); cyc();
    rst_n = 1;
    #1;
    // R1 reset state
    chk(mode == 0 && restore == 0, "R1 mode/restore", {62'h0, mode, restore}, 64'h0);
    chk(status == 0, "R1 status", {32'h0, status}, 64'h0);
    chk(r_mepc == 0 && r_mcause == 0 && r_mpp == 0 && r_mpie == 0, "R1 saved values",
        {r_mepc, r_mcause}, 64'h0);

    // External NMI taken
    set_live(2'd3, 1'b1, 32'h0000_0100, 32'h8000_000B);
    nmi_ext = 1; #2;
    chk(take == 1, "R2 take", {63'h0, take}, 64'h1);
    chk(cause == EXT_C, "R4 ext cause", {32'h0, cause}, {32'h0, EXT_C});
    push_live();
    cyc(); idle();
    chk(mode == 1, "R2 mode set", {63'h0, mode}, 64'h1);

    // Request while in NMI mode is ignored; live values change
    set_live(2'd1, 1'b0, 32'h0000_0200, 32'h0000_0007);
    nmi_int = 1; #2;
    chk(take == 0, "R3 ignored in mode", {63'h0, take}, 64'h0);
    cyc(); idle();

    // Non-MRET retire and trapped MRET
    retire = 1; insn = 32'h0000_0013; cyc(); idle();
    chk(mode == 1 && restore == 0, "R6 other word", {62'h0, mode, restore}, 64'h2);
    retire = 1; insn = MRET; trap = 1; cyc(); idle();
    chk(mode == 1 && restore == 0, "R6 trapped mret", {62'h0, mode, restore}, 64'h2);

    // Real MRET
    do_mret();
    chk(restore == 1 && mode == 0, "R7 restore cycle", {62'h0, restore, mode}, 64'h2);
    cyc();
    chk(restore == 0, "R7 one cycle", {63'h0, restore}, 64'h0);

    // Debug mode and halt request block NMI
    dbg_mode = 1; nmi_int = 1; #2;
    chk(take == 0, "R2 debug block", {63'h0, take}, 64'h0);
    idle(); halt_req = 1; nmi_ext = 1; #2;
    chk(take == 0, "R2 halt block", {63'h0, take}, 64'h0);
    cyc(); idle();
    chk(mode == 0, "R2 no mode", {63'h0, mode}, 64'h0);

    // Internal NMI
    set_live(2'd2, 1'b1, 32'h0000_0344, 32'h8000_0003);
    nmi_int = 1; #2;
    chk(take == 1, "R2 int take", {63'h0, take}, 64'h1);
    chk(cause == INT_C, "R4 int cause", {32'h0, cause}, {32'h0, INT_C});
    push_live();
    cyc(); idle();
    set_live(2'd0, 1'b0, 32'h1, 32'h1);
    do_mret();
    chk(restore == 1, "R7 restore int", {63'h0, restore}, 64'h1);
    cyc();

    // Both sources together: external wins
    set_live(2'd1, 1'b1, 32'hCAFE_0000, 32'h0000_0002);
    nmi_ext = 1; nmi_int = 1; #2;
    chk(take == 1 && cause == EXT_C, "R3 both ext wins", {31'h0, take, cause}, {31'h0, 1'b1, EXT_C});
    push_live();
    cyc(); idle();
    do_mret();
    chk(restore == 1, "R7 restore both", {63'h0, restore}, 64'h1);
    cyc();

    // Status word
    sync_exc = 1; cyc(); idle();
    chk(status == 32'h40, "R9 first exc", {32'h0, status}, 64'h40);
    sync_exc = 1; cyc(); idle();
    chk(status == 32'hC0, "R9 double fault", {32'h0, status}, 64'hC0);
    do_mret();
    chk(status == 32'h80, "R8 mret clears seen", {32'h0, status}, 64'h80);
    dbg_mode = 1; sync_exc = 1; cyc(); idle();
    chk(status == 32'h80, "R9 debug ignored", {32'h0, status}, 64'h80);
    csr_wr = 1; wdata = 32'h0000_0000; cyc(); idle();
    chk(status == 32'h0, "R10 write clears", {32'h0, status}, 64'h0);
    csr_wr = 1; wdata = 32'hFFFF_FFFF; cyc(); idle();
    chk(status == 32'hC0, "R10 write only 6/7", {32'h0, status}, 64'hC0);
    csr_wr = 1; wdata = 32'h0; sync_exc = 1; cyc(); idle();
    chk(status == 32'h0, "R10 write priority", {32'h0, status}, 64'h0);
    sync_exc = 1; retire = 1; insn = MRET; cyc(); idle();
    chk(status == 32'h40, "R11 exc beats mret", {32'h0, status}, 64'h40);
    chk(mode == 0 && restore == 0, "R7 no restore outside mode", {62'h0, mode, restore}, 64'h0);

    cyc();
    chk(exp_q.size() == 0, "R7 all restores seen", 64'(exp_q.size()), 64'h0);
    report();
  end
endmodule